// File: doc/BRIEF.md
# Parallel Poll Response Unit

This block answers a parallel poll on an 8-line data bus. Software programs a mask register. The mask selects which bits of the live status byte can raise the device's individual status flag. The flag is 1 when any masked status bit is set and 0 when none is.

The controller configures the response in two steps. It first issues a configure command (a one-cycle pulse on `ppc_cmd`). It then sends an enable byte. That byte names the data line the device answers on and the polarity of the answer.

While a poll is in progress, the unit enables its driver on the chosen line only if the flag matches the configured polarity. All other lines stay undriven. This lets several devices share one line through a passive-terminated wired-AND or wired-OR. A disable pulse returns the unit to the unconfigured state, in which it never drives.

Top module: `ppoll_responder`

## Requirements
- R1: After reset the mask register reads 0, the unit is unconfigured, and `dio_oe` is 0 even while `poll_active` is 1.
- R2: A cycle with `mask_wr` high loads `mask_wdata` into the mask register, and `mask_rdata` shows the new value after that clock edge.
- R3: `ist` is 1 exactly when `mask_rdata & status_byte` is nonzero. It follows `status_byte` in the same cycle.
- R4: An enable byte takes effect only as the first byte received after a `ppc_cmd` pulse. Any received byte ends the armed state, and a byte with no preceding `ppc_cmd` changes nothing.
- R5: A byte is an enable byte only when bits 6:5 are 11 and bit 4 is 0. Bit 7 is ignored. A non-matching byte leaves the configuration unchanged.
- R6: Bit 3 of the enable byte is the sense. Bits 2:0 give the line index (value n selects `dio_oe[n]`). While `poll_active` is 1 and the unit is configured, `dio_oe` has only bit n set if `ist` equals the sense, and is 0 otherwise.
- R7: At most one bit of `dio_oe` is ever set, and `dio_oe` is 0 whenever `poll_active` is 0. `dio_level` is 1 exactly when a line is enabled.
- R8: A `ppc_disable` pulse leaves the unit unconfigured from the next cycle on, so `dio_oe` stays 0 during polls.
- R9: A new valid command and enable byte pair replaces an existing configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write value |
| mask_rdata | output | 8 | Mask register readback |
| status_byte | input | 8 | Live status byte |
| ppc_cmd | input | 1 | Configure command received (one-cycle pulse) |
| cmd_valid | input | 1 | A command byte is present on `cmd_byte` |
| cmd_byte | input | 8 | Received command byte |
| ppc_disable | input | 1 | Clear the configuration |
| poll_active | input | 1 | A parallel poll is in progress |
| ist | output | 1 | Individual status flag |
| dio_oe | output | 8 | Per-line driver enable |
| dio_level | output | 1 | Asserted level on the enabled line |

## Verification
The mask register, the armed flag and the configuration each settle one clock edge after their strobe. The bench therefore drives every strobe on a falling edge, releases it at the next falling edge, and reads the result from then on. `ist`, `dio_oe` and `dio_level` are combinational from the registers, `status_byte` and `poll_active`. Each check changes those inputs on a falling edge and samples one time unit later, before the next rising edge.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int DIO_W = 8;
  localparam int POS_W = $clog2(DIO_W);

  typedef struct packed {
    logic             sense;
    logic [POS_W-1:0] pos;
  } ppr_cfg_t;

  // Enable byte pattern: bits 6:5 = 11, bit 4 = 0, bit 7 free
  function automatic logic is_enable_byte(input logic [7:0] b);
    return (b[6:5] == 2'b11) && !b[4];
  endfunction

  function automatic ppr_cfg_t decode_cfg(input logic [7:0] b);
    ppr_cfg_t c;
    c.sense = b[3];
    c.pos   = b[POS_W-1:0];
    return c;
  endfunction

  function automatic logic masked_any(input logic [DIO_W-1:0] m, input logic [DIO_W-1:0] s);
    return |(m & s);
  endfunction
endpackage

// File: rtl/ppr_mask_reg.sv
module ppr_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mask <= '0;
    else if (wr) mask <= wdata;
  end

  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> mask == $past(wdata));
endmodule

// File: rtl/ppr_config.sv
module ppr_config
  import ppr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ppc_cmd,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       disable_i,
  output logic       configured,
  output ppr_cfg_t   cfg
);
  logic armed;
  logic byte_ok;
  logic load;

  assign byte_ok = is_enable_byte(cmd_byte);
  assign load    = armed && cmd_valid && byte_ok && !disable_i;

  always_ff @(posedge clk) begin
    if (!rst_n || disable_i) armed <= 1'b0;
    else if (ppc_cmd)        armed <= 1'b1;
    else if (cmd_valid)      armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      configured <= 1'b0;
      cfg        <= '0;
    end else if (disable_i) begin
      configured <= 1'b0;
    end else if (load) begin
      configured <= 1'b1;
      cfg        <= decode_cfg(cmd_byte);
    end
  end

  assert_unarmed_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !armed && !disable_i) |=> ($stable(configured) && $stable(cfg)));
  assert_badbyte_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_enable_byte(cmd_byte) && !disable_i) |=> ($stable(configured) && $stable(cfg)));
  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> !configured);
endmodule

// File: rtl/ppr_drive.sv
module ppr_drive
  import ppr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_active,
  input  logic             configured,
  input  ppr_cfg_t         cfg,
  input  logic [DIO_W-1:0] mask,
  input  logic [DIO_W-1:0] status_byte,
  output logic             ist,
  output logic [DIO_W-1:0] dio_oe,
  output logic             dio_level
);
  logic respond;

  assign ist     = masked_any(mask, status_byte);
  assign respond = poll_active && configured && (ist == cfg.sense);

  for (genvar i = 0; i < DIO_W; i++) begin : g_line
    assign dio_oe[i] = respond && (cfg.pos == i[POS_W-1:0]);
  end

  assign dio_level = respond;

  assert_single_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dio_oe));
  assert_quiet_off_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_active |-> (dio_oe == '0));
  assert_no_drive_unconfigured_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !configured |-> !dio_level);
endmodule

// File: rtl/ppoll_responder.sv
module ppoll_responder
  import ppr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_wr,
  input  logic [7:0] mask_wdata,
  output logic [7:0] mask_rdata,
  input  logic [7:0] status_byte,
  input  logic       ppc_cmd,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       ppc_disable,
  input  logic       poll_active,
  output logic       ist,
  output logic [7:0] dio_oe,
  output logic       dio_level
);
  logic     configured;
  ppr_cfg_t cfg;

  ppr_mask_reg #(.W(DIO_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(mask_wdata), .mask(mask_rdata)
  );

  ppr_config u_cfg (
    .clk(clk), .rst_n(rst_n), .ppc_cmd(ppc_cmd), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .disable_i(ppc_disable), .configured(configured), .cfg(cfg)
  );

  ppr_drive u_drv (
    .clk(clk), .rst_n(rst_n), .poll_active(poll_active), .configured(configured),
    .cfg(cfg), .mask(mask_rdata), .status_byte(status_byte), .ist(ist),
    .dio_oe(dio_oe), .dio_level(dio_level)
  );
endmodule

// File: tb/ppoll_responder_bench.sv
module ppoll_responder_bench;
  localparam time PERIOD = 10;
  localparam int  NV = 8;
  // {mask, status, enable byte, expected dio_oe, expected ist}
  localparam logic [32:0] VEC [NV] = '{
    {8'h40, 8'h40, 8'h69, 8'h02, 1'b1},
    {8'h40, 8'h00, 8'h69, 8'h00, 1'b0},
    {8'h40, 8'h00, 8'h61, 8'h02, 1'b0},
    {8'h0F, 8'hF0, 8'h6F, 8'h00, 1'b0},
    {8'h0F, 8'h01, 8'hEF, 8'h80, 1'b1},
    {8'hFF, 8'h00, 8'h60, 8'h01, 1'b0},
    {8'h81, 8'h80, 8'h6C, 8'h10, 1'b1},
    {8'h00, 8'hFF, 8'h63, 8'h08, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic mask_wr = 0, ppc_cmd = 0, cmd_valid = 0, ppc_disable = 0, poll_active = 0;
  logic [7:0] mask_wdata = 0, status_byte = 0, cmd_byte = 0;
  logic [7:0] mask_rdata, dio_oe;
  logic ist, dio_level;
  int checks = 0, fails = 0;

  ppoll_responder u_ppoll_responder (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [7:0] v);
    @(negedge clk); mask_wr = 1; mask_wdata = v;
    @(negedge clk); mask_wr = 0;
  endtask

  task automatic pulse_ppc();
    @(negedge clk); ppc_cmd = 1;
    @(negedge clk); ppc_cmd = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); cmd_valid = 1; cmd_byte = b;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic poll(input logic [7:0] sb);
    @(negedge clk); status_byte = sb; poll_active = 1;
    #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    poll(8'hFF);
    chk("R1 mask", mask_rdata, 8'h00);
    chk("R1 oe", dio_oe, 8'h00);

    // vector table: R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      poll_active = 0;
      wr_mask(VEC[i][32:25]);
      chk("R2 readback", mask_rdata, VEC[i][32:25]);
      pulse_ppc();
      send_byte(VEC[i][16:9]);
      poll(VEC[i][24:17]);
      chk("R3 ist", {7'b0, ist}, {7'b0, VEC[i][0]});
      chk("R6 oe", dio_oe, VEC[i][8:1]);
      chk("R7 level", {7'b0, dio_level}, {7'b0, |VEC[i][8:1]});
    end

    // R7 poll off: no drive
    @(negedge clk); poll_active = 0; #1;
    chk("R7 idle", dio_oe, 8'h00);

    // R8 disable
    ppc_disable = 1; @(negedge clk); ppc_disable = 0;
    wr_mask(8'h40);
    poll(8'h00);
    chk("R8 disabled", dio_oe, 8'h00);

    // R4 byte with no preceding command is ignored
    poll_active = 0;
    send_byte(8'h69);
    poll(8'h40);
    chk("R4 no ppc", dio_oe, 8'h00);

    // R5 bad byte after command ignored, R4 arming consumed
    poll_active = 0;
    pulse_ppc();
    send_byte(8'h59);
    poll(8'h40);
    chk("R5 bad byte", dio_oe, 8'h00);
    poll_active = 0;
    send_byte(8'h69);
    poll(8'h40);
    chk("R4 arming consumed", dio_oe, 8'h00);

    // R9 reconfigure over an existing configuration
    poll_active = 0;
    pulse_ppc(); send_byte(8'h69);
    poll(8'h40);
    chk("R9 first cfg", dio_oe, 8'h02);
    poll_active = 0;
    pulse_ppc(); send_byte(8'h6D);
    poll(8'h40);
    chk("R9 new cfg", dio_oe, 8'h20);
    // R5 bad byte after command keeps existing config
    poll_active = 0;
    pulse_ppc(); send_byte(8'h79);
    poll(8'h40);
    chk("R5 keep cfg", dio_oe, 8'h20);

    // R1 reset again clears everything
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; #1;
    chk("R1 re-reset mask", mask_rdata, 8'h00);
    chk("R1 re-reset oe", dio_oe, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule